// File: doc/BRIEF.md
# Tightly Coupled Memory Port

This block is a single-port, zero-wait-state on-chip RAM that sits directly on a processor's memory request lines. Every cycle it may take one request made of a byte address, 32 bits of write data, a 4-bit lane write enable and a read strobe. Writes change only the lanes whose enable bit is set. Reads always return a full 32-bit word on the next clock edge.

A 4-bit size code on configuration pins picks the usable size at run time. The size is a power of two from 1 KB up to 1 MB, and code zero means the memory is absent. An access hits only when its byte address lies below both the configured size and the storage the instance actually holds. Misses are dropped on write and read as zero. Lane-enable patterns that are not an aligned word, halfword or byte are rejected and reported with a one-cycle pulse. An undefined size code behaves like an absent memory and sets a sticky error flag.

Top module: `tcm_port`

## Requirements
- R1: A read with `rd_en` high that hits returns the addressed word on `rdata` at the clock edge that takes the request. `rdata` holds its value in every cycle with `rd_en` low.
- R2: In a hitting, legal write, `byte_we[n]` writes `wdata[8n+7:8n]` into lane n of the addressed word. Lanes whose enable bit is clear keep their contents.
- R3: The legal non-zero `byte_we` values are 4'b1111, 4'b0011, 4'b1100, 4'b0001, 4'b0010, 4'b0100 and 4'b1000. Any other non-zero value leaves memory unchanged and raises `illegal_strobe` for exactly the one cycle after the request. A legal value or zero leaves `illegal_strobe` low in that cycle.
- R4: Size code k, for k from 1 to 11, gives a size of 2^(9+k) bytes (1 = 1 KB, 2 = 2 KB, 3 = 4 KB, 11 = 1 MB). An access hits only when the byte address is below that size and also below 4*DEPTH bytes.
- R5: A read that misses returns 32'h0 on the next edge. A write that misses changes no stored word.
- R6: Size code 0 makes every access miss.
- R7: Size codes 12 to 15 make every access miss and set `config_error` at the next edge. `config_error` then stays high until reset.
- R8: The word is selected by `addr[19:2]`. `addr[1:0]` has no effect on which word or lanes are accessed.
- R9: When a read and a write hit the same word in the same cycle, the read returns the contents from before the write.
- R10: After reset, `rdata` is zero and `illegal_strobe` and `config_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| size_code | input | 4 | Run-time size selection |
| addr | input | 20 | Byte address of the request |
| wdata | input | 32 | Write data, lane n in bits [8n+7:8n] |
| byte_we | input | 4 | Per-lane write enable |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid the cycle after the read |
| illegal_strobe | output | 1 | One-cycle pulse for a rejected enable pattern |
| config_error | output | 1 | Sticky flag for an undefined size code |

## Verification
Each of the block's results is due one cycle after its request. This covers read data, the illegal-pattern pulse and the config error flag. Every read pushes its expected word into a queue when it is issued. A monitor notes at the rising edge that a read was taken and pops and compares the word at the following falling edge, so each compare lands exactly one register stage after its request. The pulse and the flag are sampled at the first falling edge after the edge that took the write or the code change, and the pulse is sampled again one cycle later to confirm that it has dropped.

// File: rtl/tcm_port.sv
module tcm_port #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        size_code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] byte_we,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              illegal_strobe,
  output logic              config_error
);
  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W:0] PHYS_BYTES = (ADDR_W+1)'(DEPTH * LANES);
  localparam logic [3:0] MAX_CODE = 4'd11;

  logic [DATA_W-1:0] mem [DEPTH];

  logic            code_ok, in_cfg, in_phys, hit, legal, wr_go;
  logic [4:0]      shamt;
  logic [IDX_W-1:0] idx;

  assign code_ok = (size_code != 4'd0) && (size_code <= MAX_CODE);
  assign shamt   = 5'd9 + {1'b0, size_code};
  assign in_cfg  = (addr >> shamt) == '0;
  assign in_phys = {1'b0, addr} < PHYS_BYTES;
  assign hit     = code_ok && in_cfg && in_phys;
  assign idx     = addr[IDX_W+1:2];

  always_comb begin
    unique case (byte_we)
      4'b1111, 4'b0011, 4'b1100,
      4'b0001, 4'b0010, 4'b0100, 4'b1000: legal = 1'b1;
      default:                            legal = 1'b0;
    endcase
  end

  assign wr_go = hit && legal;

  always_ff @(posedge clk) begin
    if (wr_go)
      for (int b = 0; b < LANES; b++)
        if (byte_we[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata          <= '0;
      illegal_strobe <= 1'b0;
      config_error   <= 1'b0;
    end else begin
      if (rd_en) rdata <= hit ? mem[idx] : '0;
      illegal_strobe <= (byte_we != '0) && !legal;
      if (size_code > MAX_CODE) config_error <= 1'b1;
    end
  end
endmodule

// File: rtl/tcm_port_chk.sv
module tcm_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  size_code,
  input logic [3:0]  byte_we,
  input logic        rd_en,
  input logic [31:0] rdata,
  input logic        illegal_strobe,
  input logic        config_error
);
  logic ok_pat;
  assign ok_pat = (byte_we == 4'hF) || (byte_we == 4'h3) || (byte_we == 4'hC) ||
                  ($countones(byte_we) == 1);

  a_r3_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we != 4'h0 && !ok_pat) |=> illegal_strobe);
  a_r3_legal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we == 4'h0 || ok_pat) |=> !illegal_strobe);
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code > 4'd11) |=> config_error);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |=> config_error);
  a_r7_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size_code > 4'd11) |=> (rdata == 32'h0));
  a_r6_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size_code == 4'd0) |=> (rdata == 32'h0));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind tcm_port tcm_port_chk chk (
  .clk(clk), .rst_n(rst_n), .size_code(size_code), .byte_we(byte_we),
  .rd_en(rd_en), .rdata(rdata), .illegal_strobe(illegal_strobe),
  .config_error(config_error)
);

// File: tb/tcm_port_test.sv
`timescale 1ns/1ps
module tcm_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  size_code = 4'd3;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  byte_we = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        illegal_strobe, config_error;

  always #5 clk = ~clk;

  tcm_port uut (.clk(clk), .rst_n(rst_n), .size_code(size_code), .addr(addr),
    .wdata(wdata), .byte_we(byte_we), .rd_en(rd_en), .rdata(rdata),
    .illegal_strobe(illegal_strobe), .config_error(config_error));

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t sb[$];
  bit [31:0] model [int];
  int checks = 0, errors = 0;
  bit done = 0;
  logic pend = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit hits(input logic [3:0] c, input logic [19:0] a);
    if (c == 0 || c > 11) return 0;
    return (a < (32'd1 << (9 + c))) && (a < 32'd4096);
  endfunction

  function automatic bit legal(input logic [3:0] w);
    return w inside {4'hF, 4'h3, 4'hC, 4'h1, 4'h2, 4'h4, 4'h8};
  endfunction

  function automatic logic [31:0] peek(input logic [19:0] a);
    if (!hits(size_code, a)) return 32'h0;
    return model.exists(int'(a >> 2)) ? model[int'(a >> 2)] : 32'h0;
  endfunction

  function automatic void apply(input logic [19:0] a, input logic [31:0] d, input logic [3:0] w);
    bit [31:0] cur;
    if (!(hits(size_code, a) && legal(w))) return;
    cur = model.exists(int'(a >> 2)) ? model[int'(a >> 2)] : 32'h0;
    for (int b = 0; b < 4; b++) if (w[b]) cur[8*b +: 8] = d[8*b +: 8];
    model[int'(a >> 2)] = cur;
  endfunction

  task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic [3:0] w, input string req);
    @(negedge clk);
    addr = a; wdata = d; byte_we = w; rd_en = 0;
    apply(a, d, w);
    @(negedge clk);
    byte_we = 0;
    check({31'b0, illegal_strobe}, {31'b0, !legal(w)}, req);
    if (!legal(w)) begin
      @(negedge clk);
      check({31'b0, illegal_strobe}, 32'h0, {req, " pulse width"});
    end
  endtask

  task automatic rd(input logic [19:0] a, input string req);
    item_t it;
    @(negedge clk);
    it.exp = peek(a); it.req = req;
    sb.push_back(it);
    addr = a; rd_en = 1; byte_we = 0;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rdwr(input logic [19:0] a, input logic [31:0] d, input string req);
    item_t it;
    @(negedge clk);
    it.exp = peek(a); it.req = req;
    sb.push_back(it);
    addr = a; wdata = d; byte_we = 4'hF; rd_en = 1;
    apply(a, d, 4'hF);
    @(negedge clk);
    rd_en = 0; byte_we = 0;
  endtask

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: actual %h expected no result", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rdata, it.exp, it.req);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdata, 32'h0, "R10 rdata");
    check({31'b0, illegal_strobe}, 32'h0, "R10 illegal_strobe");
    check({31'b0, config_error}, 32'h0, "R10 config_error");
    rst_n = 1;

    size_code = 4'd3;
    wr(20'h000, 32'h11223344, 4'hF, "R3 legal word");
    wr(20'h004, 32'hAABBCCDD, 4'hF, "R3 legal word");
    wr(20'h400, 32'h0BADF00D, 4'hF, "R3 legal word");
    wr(20'h7FC, 32'h12345678, 4'hF, "R3 legal word");
    wr(20'hFFC, 32'h55AA55AA, 4'hF, "R3 legal word");
    rd(20'h000, "R1 word read");
    rd(20'h004, "R1 word read");
    repeat (3) @(negedge clk);
    check(rdata, 32'hAABBCCDD, "R1 hold");

    wr(20'h000, 32'hFFFF5566, 4'b0011, "R2 halfword");
    wr(20'h000, 32'h00770000, 4'b0100, "R2 byte");
    rd(20'h000, "R2 lanes merged");
    check(model[0], 32'h11775566, "R2 model");

    wr(20'h004, 32'h00000000, 4'b0101, "R3 illegal 0101");
    wr(20'h004, 32'h00000000, 4'b0110, "R3 illegal 0110");
    wr(20'h004, 32'h00000000, 4'b0111, "R3 illegal 0111");
    rd(20'h004, "R3 dropped write");

    rd(20'h003, "R8 low bits ignored");
    wr(20'h006, 32'h99000000, 4'b1000, "R8 byte lane by enable");
    rd(20'h005, "R8 lane write");

    size_code = 4'd1;
    wr(20'h3FC, 32'hCAFEF00D, 4'hF, "R4 1KB top");
    rd(20'h3FC, "R4 1KB top hit");
    wr(20'h400, 32'h0000DEAD, 4'hF, "R5 miss write");
    rd(20'h400, "R5 miss read zero");
    size_code = 4'd3;
    rd(20'h400, "R5 miss write dropped");

    size_code = 4'd2;
    rd(20'h7FC, "R4 2KB top hit");
    rd(20'h800, "R4 2KB beyond");

    size_code = 4'd11;
    rd(20'hFFC, "R4 physical top hit");
    rd(20'h01000, "R4 physical limit");

    size_code = 4'd0;
    rd(20'h000, "R6 absent");
    wr(20'h000, 32'h0, 4'hF, "R6 absent write");
    size_code = 4'd3;
    rd(20'h000, "R6 write dropped");

    rdwr(20'h000, 32'hFEEDBEEF, "R9 old data");
    rd(20'h000, "R9 new data");

    check({31'b0, config_error}, 32'h0, "R7 before bad code");
    size_code = 4'd12;
    rd(20'h000, "R7 no hit");
    @(negedge clk);
    check({31'b0, config_error}, 32'h1, "R7 flag set");
    size_code = 4'd3;
    rd(20'h000, "R7 normal after");
    repeat (2) @(negedge clk);
    check({31'b0, config_error}, 32'h1, "R7 sticky");

    repeat (3) @(negedge clk);
    check(sb.size(), 0, "R1 queue drained");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule